// File: doc/BRIEF.md
# ROM Self-Test Signature Generator

This block is a built-in self-test engine for an embedded read-only memory. Software or a test controller writes a one-bit command register to start it. The engine then reads every word of the ROM exactly once, in a fixed order that pairs each address with its bitwise complement. It folds each returned word into two 16-bit CRC compressors, one for the low half of the word and one for the high half.

Each compressor uses the polynomial x^16 + x^12 + x^5 + 1. While the test runs, a single test pin carries a quotient bit from the compressors, so an external monitor can watch the compression as it happens. When the last word has been folded in, a done flag rises. A pass flag reports whether both signatures equal expected values that are fixed by parameters when the block is built.

The ROM itself sits outside the block. It is a synchronous memory: it returns a word one clock after it receives an enabled address. Clearing the command register at any time stops the test, returns the engine to idle, and leaves the signatures frozen for inspection.

Top module: `rom_sig_bist`

## Requirements
- R1: After reset, busy, done, pass, rom_en and test_pin are 0, and both signature outputs are 16'h0000.
- R2: Writing cmd_run=1 (with cmd_we=1) while busy is low starts a test. From the next cycle, busy and rom_en are 1, both signatures read 16'hFFFF, and done and pass are 0.
- R3: A test issues one address per cycle for N = 2^ADDR_W consecutive cycles, with rom_en high in exactly those cycles. For step k = 0..N-1, the address is k/2 when k is even, and the bitwise complement of (k-1)/2 when k is odd.
- R4: Over one test, every ROM address is issued exactly once.
- R5: The word returned one cycle after each address is compressed. Bits 15:0 go to sig_lo and bits 31:16 go to sig_hi. Each update shifts the 16 data bits in MSB first: the feedback bit is crc[15] XOR the data bit, the register shifts left by one, and 16'h1021 is XORed in when the feedback bit is 1.
- R6: test_pin is updated with each compressed word. It shows the XOR of the two compressors' last feedback bits, meaning the bits from data bit 0 of that word. It is cleared at test start.
- R7: done rises exactly N+1 cycles after the start write edge. At the same time busy falls and the final signatures appear. done and the signatures then hold until the next command write.
- R8: pass is 1 only while done is 1, and only if sig_lo equals EXP_LO and sig_hi equals EXP_HI. A ROM whose content differs in a single bit gives pass=0 at done.
- R9: Writing cmd_run=1 while busy is high is ignored. The test finishes at the same cycle, with the same signatures it would have had without the write.
- R10: Writing cmd_run=0 aborts the test. From the next cycle, busy, rom_en, done and pass are 0, and the signatures keep the values they had just before the write edge. They stay unchanged while the engine is idle.
- R11: A new start after done or after an abort presets both signatures again. A clean run then gives the same final signatures as a test started from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_run | input | 1 | Command bit: 1 starts a test, 0 aborts it |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | ADDR_W | ROM read address |
| rom_data | input | DATA_W | ROM read data, valid one cycle after an enabled address |
| busy | output | 1 | A test is in progress |
| done | output | 1 | The last word has been compressed |
| pass | output | 1 | Both signatures match the expected values (valid with done) |
| sig_lo | output | 16 | Signature of data bits 15:0 |
| sig_hi | output | 16 | Signature of data bits 31:16 |
| test_pin | output | 1 | Quotient bit observed while the test runs |

## Verification
The assertions assume that the ROM behaves as a one-cycle synchronous memory. They also assume that the command strobe is never asserted during reset, and that an abort write is a single strobe rather than being combined with a start in the same cycle. The bench models the ROM in exactly that way, computing each word from its address. It drives command writes only at falling edges and holds each one for one cycle. This keeps the address-pairing, hold and start properties within the conditions they rely on. Expected signatures are computed by the bench from the same address order and the same bitwise compression rule.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    // Fold a 16-bit word into a CRC, MSB first.
    // Returns {last feedback bit, new crc}.
    function automatic logic [16:0] crc16_fold(input logic [15:0] crc_in,
                                               input logic [15:0] word);
        logic [15:0] c;
        logic        fb;
        c  = crc_in;
        fb = 1'b0;
        for (int b = 15; b >= 0; b--) begin
            fb = c[15] ^ word[b];
            c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return {fb, c};
    endfunction

endpackage

// File: rtl/rsb_addr_seq.sv
module rsb_addr_seq #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base = {1'b0, step[ADDR_W-1:1]};
        addr = step[0] ? ~base : base;
    end
endmodule

// File: rtl/rsb_crc16.sv
module rsb_crc16
    import rsb_pkg::*;
(
    input  logic [15:0] crc_in,
    input  logic [15:0] word,
    output logic [15:0] crc_out,
    output logic        qbit
);
    logic [16:0] res;

    always_comb begin
        res     = crc16_fold(crc_in, word);
        crc_out = res[15:0];
        qbit    = res[16];
    end
endmodule

// File: rtl/rom_sig_bist.sv
module rom_sig_bist
    import rsb_pkg::*;
#(
    parameter int          ADDR_W = 6,
    parameter int          DATA_W = 32,
    parameter logic [15:0] EXP_LO = 16'h0000,
    parameter logic [15:0] EXP_HI = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              cmd_run,
    output logic              rom_en,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_data,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [15:0]       sig_lo,
    output logic [15:0]       sig_hi,
    output logic              test_pin
);
    localparam int                LANES    = DATA_W / CRC_W;
    localparam logic [ADDR_W-1:0] LAST_STP = {ADDR_W{1'b1}};

    typedef struct packed {
        logic                   run;
        logic [ADDR_W-1:0]      stp;
        logic                   rd_vld;
        logic                   rd_last;
        logic                   done;
        logic                   pass;
        logic [LANES-1:0][15:0] sig;
        logic                   tpin;
    } st_t;

    st_t st_d, st_q;

    logic [LANES-1:0][15:0] sig_nx;
    logic [LANES-1:0]       q_bits;
    logic [ADDR_W-1:0]      addr_w;

    rsb_addr_seq #(.ADDR_W(ADDR_W)) addr_i (
        .step (st_q.stp),
        .addr (addr_w)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rsb_crc16 crc_i (
            .crc_in  (st_q.sig[g]),
            .word    (rom_data[g*CRC_W +: CRC_W]),
            .crc_out (sig_nx[g]),
            .qbit    (q_bits[g])
        );
    end

    logic busy_w;
    assign busy_w = st_q.run | st_q.rd_vld;

    always_comb begin
        st_d         = st_q;
        st_d.rd_vld  = 1'b0;
        st_d.rd_last = 1'b0;

        if (cmd_we && !cmd_run) begin
            st_d.run  = 1'b0;
            st_d.done = 1'b0;
            st_d.pass = 1'b0;
        end else if (cmd_we && cmd_run && !busy_w) begin
            st_d.run  = 1'b1;
            st_d.stp  = '0;
            st_d.done = 1'b0;
            st_d.pass = 1'b0;
            st_d.tpin = 1'b0;
            for (int l = 0; l < LANES; l++) st_d.sig[l] = CRC_SEED;
        end else begin
            if (st_q.rd_vld) begin
                st_d.sig  = sig_nx;
                st_d.tpin = ^q_bits;
                if (st_q.rd_last) begin
                    st_d.done = 1'b1;
                    st_d.pass = (sig_nx[0] == EXP_LO) && (sig_nx[LANES-1] == EXP_HI);
                end
            end
            if (st_q.run) begin
                st_d.rd_vld  = 1'b1;
                st_d.rd_last = (st_q.stp == LAST_STP);
                if (st_q.stp == LAST_STP) st_d.run = 1'b0;
                else                      st_d.stp = st_q.stp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rom_en   = st_q.run;
    assign rom_addr = addr_w;
    assign busy     = busy_w;
    assign done     = st_q.done;
    assign pass     = st_q.pass;
    assign sig_lo   = st_q.sig[0];
    assign sig_hi   = st_q.sig[LANES-1];
    assign test_pin = st_q.tpin;

endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic              cmd_run,
    input logic              rom_en,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic [15:0]       sig_lo,
    input logic [15:0]       sig_hi
);
    assert_start_preset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_run && !busy) |=> (rom_en && busy && !done && sig_lo == 16'hFFFF && sig_hi == 16'hFFFF));

    assert_en_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en |-> busy);

    assert_addr_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_en && $past(rom_en) && rom_addr[ADDR_W-1]) |-> (rom_addr == ~$past(rom_addr)));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_pass_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cmd_run) |=> (!busy && !rom_en && !done && !pass));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_we && cmd_run)) |=> ($stable(sig_lo) && $stable(sig_hi)));
endmodule

bind rom_sig_bist rsb_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .cmd_run  (cmd_run),
    .rom_en   (rom_en),
    .rom_addr (rom_addr),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .sig_lo   (sig_lo),
    .sig_hi   (sig_hi)
);

// File: tb/rom_sig_bist_tb_top.sv
module rom_sig_bist_tb_top;
    localparam int AW = 6;
    localparam int N  = 1 << AW;
    localparam int BAD_ADDR = 5;

    function automatic logic [31:0] rom_word(input int a, input logic bad);
        logic [15:0] lo, hi;
        logic [31:0] w;
        lo = 16'(a * 37 + 16'h1234) ^ 16'hBEEF;
        hi = 16'(a * a * 5) ^ 16'h5A5A;
        w  = {hi, lo};
        if (bad && a == BAD_ADDR) w[3] = ~w[3];
        return w;
    endfunction

    // Returns {qbit, crc} for one 16-bit word, MSB first.
    function automatic logic [16:0] fold(input logic [15:0] c0, input logic [15:0] d);
        logic [15:0] c;
        logic        f;
        c = c0;
        f = 1'b0;
        for (int b = 15; b >= 0; b--) begin
            f = c[15] ^ d[b];
            c = {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
        end
        return {f, c};
    endfunction

    function automatic int seq_addr(input int k);
        int base;
        base = k / 2;
        return (k % 2 == 0) ? base : ((~base) & (N - 1));
    endfunction

    // Returns {test_pin, sig_hi, sig_lo} after a full run.
    function automatic logic [32:0] model(input logic bad);
        logic [15:0] lo, hi;
        logic [16:0] rl, rh;
        logic [31:0] w;
        lo = 16'hFFFF;
        hi = 16'hFFFF;
        rl = '0;
        rh = '0;
        for (int k = 0; k < N; k++) begin
            w  = rom_word(seq_addr(k), bad);
            rl = fold(lo, w[15:0]);
            rh = fold(hi, w[31:16]);
            lo = rl[15:0];
            hi = rh[15:0];
        end
        return {rl[16] ^ rh[16], hi, lo};
    endfunction

    localparam logic [32:0] GOOD = model(1'b0);
    localparam logic [32:0] BAD  = model(1'b1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic          cmd_run = 1'b0;
    logic          rom_en;
    logic [AW-1:0] rom_addr;
    logic [31:0]   rom_data = '0;
    logic          busy, done, pass, test_pin;
    logic [15:0]   sig_lo, sig_hi;
    logic          bad = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int log_n = 0;
    int log_a [0:2*N-1];
    bit log_on = 1'b0;

    always #2.5 clk = ~clk;

    rom_sig_bist #(.ADDR_W(AW), .DATA_W(32), .EXP_LO(GOOD[15:0]), .EXP_HI(GOOD[31:16])) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_run(cmd_run),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_data),
        .busy(busy), .done(done), .pass(pass),
        .sig_lo(sig_lo), .sig_hi(sig_hi), .test_pin(test_pin)
    );

    always @(posedge clk) if (rom_en) rom_data <= rom_word(int'(rom_addr), bad);

    always @(negedge clk) begin
        if (log_on && rom_en && log_n < 2 * N) begin
            log_a[log_n] = int'(rom_addr);
        end
        if (log_on && rom_en) log_n = log_n + 1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic write_cmd(input logic v);
        @(negedge clk);
        cmd_we  = 1'b1;
        cmd_run = v;
        @(negedge clk);
        cmd_we  = 1'b0;
    endtask

    // Start, count edges until done. Optional second start write at cycle 'again' (0 = none).
    task automatic run_to_done(input int again, output int cyc);
        cyc = 0;
        write_cmd(1'b1);
        cyc = 1;
        while (!done && cyc < 4 * N) begin
            if (again != 0 && cyc == again) begin
                cmd_we = 1'b1; cmd_run = 1'b1;
            end
            @(negedge clk);
            cmd_we = 1'b0;
            if (!done) cyc++;
        end
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 pass", pass, 0);
        check("R1 rom_en", rom_en, 0);
        check("R1 test_pin", test_pin, 0);
        check("R1 sigs", {sig_hi, sig_lo}, 0);
    endtask

    task automatic t_full();
        int cyc;
        int seen [0:N-1];
        bit order_ok;
        foreach (seen[i]) seen[i] = 0;
        log_n = 0;
        log_on = 1'b1;
        write_cmd(1'b1);
        check("R2 busy after start", busy, 1);
        check("R2 rom_en after start", rom_en, 1);
        check("R2 preset", {sig_hi, sig_lo}, 32'hFFFF_FFFF);
        check("R2 done low", done, 0);
        cyc = 1;
        while (!done && cyc < 4 * N) begin
            @(negedge clk);
            if (!done) cyc++;
        end
        log_on = 1'b0;
        check("R7 done latency", cyc, N + 1);
        check("R7 busy low at done", busy, 0);
        check("R3 enable count", log_n, N);
        order_ok = 1'b1;
        for (int k = 0; k < N && k < log_n; k++) begin
            if (log_a[k] != seq_addr(k)) order_ok = 1'b0;
            seen[log_a[k]]++;
        end
        check("R3 address order", order_ok, 1);
        begin
            bit once = 1'b1;
            foreach (seen[i]) if (seen[i] != 1) once = 1'b0;
            check("R4 each address once", once, 1);
        end
        check("R5 sig_lo", sig_lo, GOOD[15:0]);
        check("R5 sig_hi", sig_hi, GOOD[31:16]);
        check("R6 test_pin", test_pin, GOOD[32]);
        check("R8 pass good", pass, 1);
        repeat (4) @(negedge clk);
        check("R7 done holds", done, 1);
        check("R7 sig holds", {sig_hi, sig_lo}, GOOD[31:0]);
    endtask

    task automatic t_ignore_restart();
        int cyc;
        run_to_done(9, cyc);
        check("R9 latency unchanged", cyc, N + 1);
        check("R9 signature unchanged", {sig_hi, sig_lo}, GOOD[31:0]);
        check("R9 pass", pass, 1);
    endtask

    task automatic t_corrupt();
        int cyc;
        bad = 1'b1;
        run_to_done(0, cyc);
        check("R8 corrupt signature", {sig_hi, sig_lo}, BAD[31:0]);
        check("R8 corrupt pass low", pass, 0);
        check("R8 corrupt done", done, 1);
        bad = 1'b0;
    endtask

    task automatic t_abort();
        logic [31:0] held;
        write_cmd(1'b1);
        repeat (10) @(negedge clk);
        held = {sig_hi, sig_lo};
        cmd_we = 1'b1; cmd_run = 1'b0;
        @(negedge clk);
        cmd_we = 1'b0;
        check("R10 busy low", busy, 0);
        check("R10 rom_en low", rom_en, 0);
        check("R10 done low", done, 0);
        check("R10 sig held", {sig_hi, sig_lo}, held);
        repeat (6) @(negedge clk);
        check("R10 sig still held", {sig_hi, sig_lo}, held);
        check("R10 still idle", busy, 0);
    endtask

    task automatic t_rerun();
        int cyc;
        run_to_done(0, cyc);
        check("R11 rerun latency", cyc, N + 1);
        check("R11 rerun signature", {sig_hi, sig_lo}, GOOD[31:0]);
        check("R11 rerun pass", pass, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_full();
        t_ignore_restart();
        t_corrupt();
        t_abort();
        t_rerun();
        finish_run();
    end
endmodule